// File: doc/BRIEF.md
# Dual-Output Serial Flash Read Controller

This block is the host side of a serial flash read path. It uses the command that returns data on two lines at once. A client presents a start address and a byte count, then pulses a start input.

The controller drops chip select and generates the serial clock from the system clock through a fixed divider, using SPI mode 0. It sends the one-byte command and a 24-bit address on IO0, most significant bit first. It then runs eight dummy clocks and releases IO0 so the flash can drive it. From that point it captures two bits on every rising serial-clock edge: the odd bit on IO1 and the even bit on IO0.

Each assembled byte is presented on a valid/ready output. When the consumer stalls, the serial clock stops low at a byte boundary, so no byte is lost. Once the requested count has been captured, chip select rises. The block stays busy for one more full serial-clock period and then returns to idle.

The state machine has these states:
- `ST_IDLE` goes to `ST_CMD` on start with a nonzero count.
- `ST_CMD` goes to `ST_ADDR` after clock 7.
- `ST_ADDR` goes to `ST_DUMMY` after clock 31.
- `ST_DUMMY` goes to `ST_DATA` after clock 39.
- `ST_DATA` goes to `ST_HOLD` at a byte boundary while the output slot is still full. It goes to `ST_DESEL` at a byte boundary after the last byte.
- `ST_HOLD` goes back to `ST_DATA` once the slot is free.
- `ST_DESEL` goes to `ST_IDLE` after 2×`SCLK_HALF` system cycles.

Each move out of a clocked state happens on a falling serial-clock tick.

Top module: `dual_read_ctrl`

## Requirements
- R1: After reset, `cs_n_o` is 1, and `sclk_o`, `busy_o`, `byte_valid_o` and `io0_oe_o` are 0.
- R2: The command byte 0x3B is sent on IO0, MSB first, during serial clocks 0 to 7. IO0 changes only while `sclk_o` is low, and the flash samples it on the rising edge.
- R3: The address follows on IO0, MSB first, during clocks 8 to 31. Its bits 23 to 20 are always sent as 0, whatever `addr_i` holds.
- R4: Eight dummy clocks, 32 to 39, follow the address. `io0_oe_o` drops at the falling edge after clock 31 and stays 0 while the flash drives data.
- R5: From clock 40 on, each byte takes four clocks. The first clock carries bit 7 on IO1 and bit 6 on IO0, then bits 5/4, 3/2 and 1/0. Bytes come from consecutive addresses.
- R6: Exactly `len_i` bytes are delivered, using exactly 40 + 4×`len_i` serial clocks, and then `cs_n_o` rises. A start with `len_i` = 0 is ignored.
- R7: While a delivered byte waits unaccepted, the next byte boundary holds `sclk_o` low. No byte is lost or overwritten, and `byte_data_o` stays stable while `byte_valid_o` is 1 and `byte_ready_i` is 0.
- R8: `busy_o` rises in the cycle after the accepted start. It falls after `cs_n_o` has been high for 2×`SCLK_HALF` system cycles. A start while busy is ignored.
- R9: Each high phase of `sclk_o` lasts `SCLK_HALF` system cycles, and `sclk_o` is low whenever `cs_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a read |
| addr_i | input | 24 | Start byte address |
| len_i | input | LEN_W | Number of bytes to read |
| busy_o | output | 1 | Transaction in progress |
| cs_n_o | output | 1 | Flash chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| io0_o | output | 1 | Host value for IO0 |
| io0_oe_o | output | 1 | Host drive enable for IO0 |
| io0_i | input | 1 | IO0 level from the pad |
| io1_i | input | 1 | IO1 level from the pad |
| byte_data_o | output | 8 | Received byte |
| byte_valid_o | output | 1 | Received byte is present |
| byte_ready_i | input | 1 | Consumer accepts the byte |

## Verification
Several properties are checked on every cycle:
- the serial clock is quiet while deselected;
- IO0 is released during the dummy and data phases;
- no byte is loaded into a full output slot, and a stalled byte is held steady;
- the clock stays low in the hold state;
- chip select rises only with zero bytes left;
- the transaction is entered only from idle.

Other behaviour only the bench scenarios can show. These are the exact command and truncated address seen by a flash model, the pairing of odd and even bits into bytes, the total clock count under different backpressure patterns, the deselect time before busy falls, and the rejection of zero-length and overlapping starts.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
    localparam logic [7:0] DFR_CMD_DUAL = 8'h3B;
    localparam logic [5:0] HDR_CMD_END   = 6'd8;
    localparam logic [5:0] HDR_ADDR_END  = 6'd32;
    localparam logic [5:0] HDR_DUMMY_END = 6'd40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_HOLD,
        ST_DESEL
    } dfr_state_e;
endpackage

// File: rtl/dfr_sclk_gen.sv
module dfr_sclk_gen #(
    parameter int SCLK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int HW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

    logic [HW-1:0] cnt_q;
    logic          tick;

    assign tick   = en_i && (cnt_q == HW'(SCLK_HALF - 1));
    assign rise_o = tick && !sclk_o;
    assign fall_o = tick && sclk_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_o <= 1'b0;
        end else if (!en_i) begin
            cnt_q  <= '0;
            sclk_o <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            sclk_o <= ~sclk_o;
        end else begin
            cnt_q  <= cnt_q + HW'(1);
        end
    end

    // R9: the clock only starts a high phase while the controller enables it
    assert_sclk_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $past(en_i));
endmodule

// File: rtl/dfr_tx_shift.sv
module dfr_tx_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         shift_i,
    output logic         bit_o
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sh_q <= '0;
        else if (load_i)  sh_q <= data_i;
        else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
    end

    assign bit_o = sh_q[W-1];
endmodule

// File: rtl/dfr_rx_pair.sv
module dfr_rx_pair (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_i,
    input  logic       odd_i,
    input  logic       even_i,
    output logic [7:0] byte_o
);
    logic [5:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        acc_q <= '0;
        else if (sample_i) acc_q <= {acc_q[3:0], odd_i, even_i};
    end

    // the byte completed by the pair now on the lines
    assign byte_o = {acc_q, odd_i, even_i};
endmodule

// File: rtl/dual_read_ctrl.sv
module dual_read_ctrl
    import dfr_pkg::*;
#(
    parameter int SCLK_HALF = 2,
    parameter int LEN_W     = 16,
    parameter int ARRAY_AW  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [23:0]      addr_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             busy_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             io0_o,
    output logic             io0_oe_o,
    input  logic             io0_i,
    input  logic             io1_i,
    output logic [7:0]       byte_data_o,
    output logic             byte_valid_o,
    input  logic             byte_ready_i
);
    localparam int DESEL_CYC = 2 * SCLK_HALF;
    localparam int DW        = $clog2(DESEL_CYC + 1);
    localparam int HDR_BITS  = 32;

    dfr_state_e       state_q, state_d;
    logic [5:0]       hdr_q;
    logic [1:0]       pair_q;
    logic [LEN_W-1:0] left_q;
    logic [DW-1:0]    desel_q;
    logic [7:0]       out_q;
    logic             out_v_q;

    logic             gen_en, rise_w, fall_w;
    logic             go_w, ld_byte, shift_w, tx_bit;
    logic [7:0]       rx_byte;
    logic [23:0]      addr_eff;

    // address bits above the array size are sent as zero
    generate
        if (ARRAY_AW < 24) begin : g_mask
            assign addr_eff = {{(24 - ARRAY_AW){1'b0}}, addr_i[ARRAY_AW-1:0]};
        end else begin : g_full
            assign addr_eff = addr_i;
        end
    endgenerate

    assign go_w    = (state_q == ST_IDLE) && start_i && (len_i != '0);
    assign gen_en  = (state_q == ST_CMD) || (state_q == ST_ADDR) ||
                     (state_q == ST_DUMMY) || (state_q == ST_DATA);
    assign shift_w = fall_w && ((state_q == ST_CMD) || (state_q == ST_ADDR));
    assign ld_byte = rise_w && (state_q == ST_DATA) && (pair_q == 2'd3);

    dfr_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_gen (
        .clk(clk), .rst_n(rst_n), .en_i(gen_en),
        .sclk_o(sclk_o), .rise_o(rise_w), .fall_o(fall_w)
    );

    dfr_tx_shift #(.W(HDR_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n), .load_i(go_w),
        .data_i({DFR_CMD_DUAL, addr_eff}), .shift_i(shift_w), .bit_o(tx_bit)
    );

    dfr_rx_pair u_rx (
        .clk(clk), .rst_n(rst_n), .sample_i(rise_w && (state_q == ST_DATA)),
        .odd_i(io1_i), .even_i(io0_i), .byte_o(rx_byte)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go_w) state_d = ST_CMD;
            ST_CMD:   if (fall_w && hdr_q == HDR_CMD_END) state_d = ST_ADDR;
            ST_ADDR:  if (fall_w && hdr_q == HDR_ADDR_END) state_d = ST_DUMMY;
            ST_DUMMY: if (fall_w && hdr_q == HDR_DUMMY_END) state_d = ST_DATA;
            ST_DATA: begin
                if (fall_w && pair_q == 2'd0) begin
                    if (left_q == '0)                     state_d = ST_DESEL;
                    else if (out_v_q && !byte_ready_i)    state_d = ST_HOLD;
                end
            end
            ST_HOLD:  if (!out_v_q || byte_ready_i) state_d = ST_DATA;
            ST_DESEL: if (desel_q == DW'(DESEL_CYC - 1)) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // counters and output slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q   <= '0;
            pair_q  <= '0;
            left_q  <= '0;
            desel_q <= '0;
            out_q   <= '0;
            out_v_q <= 1'b0;
        end else begin
            if (go_w) begin
                hdr_q  <= '0;
                pair_q <= '0;
                left_q <= len_i;
            end else if (rise_w && state_q != ST_DATA) begin
                hdr_q <= hdr_q + 6'd1;
            end else if (rise_w) begin
                pair_q <= pair_q + 2'd1;
                if (pair_q == 2'd3) left_q <= left_q - {{(LEN_W-1){1'b0}}, 1'b1};
            end
            desel_q <= (state_q == ST_DESEL) ? desel_q + DW'(1) : '0;
            if (ld_byte) begin
                out_q   <= rx_byte;
                out_v_q <= 1'b1;
            end else if (out_v_q && byte_ready_i) begin
                out_v_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        cs_n_o       = (state_q == ST_IDLE) || (state_q == ST_DESEL);
        io0_oe_o     = (state_q == ST_CMD) || (state_q == ST_ADDR);
        io0_o        = io0_oe_o & tx_bit;
        byte_data_o  = out_q;
        byte_valid_o = out_v_q;
    end

    assert_quiet_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    assert_io0_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_w && hdr_q >= HDR_ADDR_END) |-> !io0_oe_o);

    assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_byte |-> (!out_v_q || byte_ready_i));

    assert_stall_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_data_o)));

    assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !sclk_o);

    assert_count_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (left_q == '0));

    assert_enter_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD && $past(state_q) != ST_CMD) |-> $past(state_q) == ST_IDLE);
endmodule

// File: tb/dual_read_ctrl_tb.sv
module dual_read_ctrl_tb;
    localparam int HALF = 2;
    localparam int NV   = 5;
    // {addr, len, ready mode}; mode 0 always ready, 1 every third cycle, 2 late
    localparam logic [33:0] VECS [NV] = '{
        {24'h000000, 8'd1, 2'd0},
        {24'h0ABCDE, 8'd4, 2'd0},
        {24'hF12345, 8'd3, 2'd1},
        {24'h0FFFFE, 8'd5, 2'd2},
        {24'h955555, 8'd2, 2'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [23:0] addr = '0;
    logic [15:0] len = '0;
    logic busy, cs_n, sclk, io0, io0_oe, bvalid;
    logic f_io0 = 1'b0, f_io1 = 1'b0, bready = 1'b0;
    logic [7:0] bdata;

    int tests = 0, fails = 0;
    int mode = 0, cyc_tx = 0, got_n = 0;
    int desel_run = 0, hi_run = 0, sclk_err = 0, quiet_err = 0;
    int f_cnt = 0, xfers = 0, oe_err = 0;
    logic [7:0]  f_cmd = '0;
    logic [23:0] f_addr = '0;
    logic [7:0]  got [32];

    always #10 clk = ~clk;

    dual_read_ctrl #(.SCLK_HALF(HALF), .LEN_W(16), .ARRAY_AW(20)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .len_i(len),
        .busy_o(busy), .cs_n_o(cs_n), .sclk_o(sclk), .io0_o(io0), .io0_oe_o(io0_oe),
        .io0_i(f_io0), .io1_i(f_io1), .byte_data_o(bdata), .byte_valid_o(bvalid),
        .byte_ready_i(bready)
    );

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'hA5;
    endfunction

    // behavioural flash responder
    always @(negedge cs_n) begin
        f_cnt = 0; f_cmd = '0; f_addr = '0; xfers++;
    end
    always @(posedge sclk) if (!cs_n) begin
        if (f_cnt < 8)       f_cmd  = {f_cmd[6:0], io0};
        else if (f_cnt < 32) f_addr = {f_addr[22:0], io0};
        if (f_cnt < 32 && !io0_oe) oe_err++;
        f_cnt++;
    end
    always @(negedge sclk) if (!cs_n && f_cnt >= 40) begin
        automatic int p = f_cnt - 40;
        automatic logic [7:0] b = mem_byte(f_addr[19:0] + 20'(p / 4));
        f_io1 = b[7 - 2 * (p % 4)];
        f_io0 = b[6 - 2 * (p % 4)];
        if (io0_oe) oe_err++;
    end

    // consumer and monitors
    always @(negedge clk) begin
        cyc_tx++;
        case (mode)
            0: bready = 1'b1;
            1: bready = (cyc_tx % 3 == 0);
            default: bready = (cyc_tx > 260);
        endcase
        if (bvalid && bready && got_n < 32) begin
            got[got_n] = bdata;
            got_n++;
        end
        if (cs_n && busy) desel_run++;
        if (cs_n && sclk) quiet_err++;
        if (sclk) hi_run++;
        else if (hi_run != 0) begin
            if (hi_run != HALF) sclk_err++;
            hi_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle(input int cap);
        for (int i = 0; i < cap && busy; i++) @(negedge clk);
    endtask

    task automatic pulse_start(input logic [23:0] a, input logic [15:0] n);
        @(negedge clk);
        addr = a; len = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_read(input logic [23:0] a, input int n, input int m);
        mode = m; cyc_tx = 0; got_n = 0; desel_run = 0;
        pulse_start(a, 16'(n));
        chk(busy && !cs_n, "R8 busy after start", {30'd0, busy, cs_n}, 2);
        wait_idle(20000);
        for (int i = 0; i < 400 && got_n < n; i++) @(negedge clk);
        chk(f_cmd == 8'h3B, "R2 command", f_cmd, 8'h3B);
        chk(f_addr == {4'h0, a[19:0]}, "R3 address", f_addr, {4'h0, a[19:0]});
        chk(got_n == n, "R6 byte count", got_n, n);
        chk(f_cnt == 40 + 4 * n, "R6 R7 clock count", f_cnt, 40 + 4 * n);
        for (int i = 0; i < n && i < got_n; i++)
            chk(got[i] == mem_byte(a[19:0] + 20'(i)), "R5 R7 data", got[i],
                mem_byte(a[19:0] + 20'(i)));
        chk(desel_run == 2 * HALF, "R8 deselect time", desel_run, 2 * HALF);
    endtask

    initial begin
        #3000000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n && !sclk && !busy && !bvalid && !io0_oe, "R1 reset outputs",
            {27'd0, cs_n, sclk, busy, bvalid, io0_oe}, 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++)
            do_read(VECS[v][33:10], int'(VECS[v][9:2]), int'(VECS[v][1:0]));

        // R6: zero-length start is ignored
        begin
            automatic int x0 = xfers;
            pulse_start(24'h000100, 16'd0);
            repeat (20) @(negedge clk);
            chk(!busy && cs_n && xfers == x0, "R6 zero length ignored", xfers, x0);
        end

        // R8: a second start during a transaction is ignored
        begin
            automatic int x0 = xfers;
            mode = 0; cyc_tx = 0; got_n = 0; desel_run = 0;
            pulse_start(24'h012340, 16'd2);
            repeat (100) @(negedge clk);
            pulse_start(24'h0ABCD0, 16'd5);
            wait_idle(20000);
            repeat (10) @(negedge clk);
            chk(xfers == x0 + 1, "R8 single transaction", xfers, x0 + 1);
            chk(got_n == 2, "R8 first count kept", got_n, 2);
            chk(f_addr == 24'h012340, "R8 first address kept", f_addr, 24'h012340);
        end

        chk(oe_err == 0, "R4 IO0 release", oe_err, 0);
        chk(sclk_err == 0, "R9 high phase", sclk_err, 0);
        chk(quiet_err == 0, "R9 quiet while deselected", quiet_err, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule